// File: doc/BRIEF.md
# Auto-Baud Serial Download Receiver

This block takes in a serial download stream for a boot loader. It starts its asynchronous receiver at a fast default bit rate. The first character the host sends is a sync byte of all ones. When the host sends that byte at the slow rate, the fast receiver misreads it in a predictable way, and the block uses that misread value to pick the rate it will use for the rest of the download. No edge timing is measured.

After the sync byte, each received byte goes out through a simple write port. Addresses start at zero and go up by one for each byte. Each byte is also sent back on an open-drain style transmit output so the host can verify the download. There is no length field. The download ends when no new character completes within a programmed number of clock cycles. The block then pulses `done` and ignores the line until the next reset.

Top module: `autobaud_loader`

## Requirements
- R1: After reset the outputs are as follows: `txDriveLow`=0 (line released), `wrEn`=0, `wrAddr`=0, `slowRate`=0, `syncErr`=0 and `done`=0.
- R2: The receiver starts at the fast rate. One fast bit lasts 16*FAST_DIV clocks. A first character of 0xFF keeps the fast rate and leaves `syncErr` at 0.
- R3: A first character that decodes as 0xC0 or 0xE0 sets `slowRate`=1. From then on every character is received and echoed with a bit time of 16*SLOW_DIV clocks. This includes the case where 0xFF is sent at the slow rate. `slowRate` does not fall again before reset.
- R4: Any other first character sets `syncErr`=1 and keeps the fast rate. The download still proceeds. `syncErr` and `slowRate` are never both 1.
- R5: The sync character is neither written nor echoed. Each later byte is written with one `wrEn` cycle. The first byte goes to `wrAddr`=0, and the address rises by exactly 1 after each write and holds otherwise.
- R6: Each written byte is sent back as 8N1 with the least significant bit first. `txDriveLow`=1 pulls the line low (a 0 bit), and 0 releases it (a 1 bit or idle).
- R7: A frame is a start bit (low), 8 data bits with the least significant bit first, and a stop bit. The start bit is confirmed low at mid-bit, and data bits are sampled at their centres using 16 ticks per bit. A frame whose stop bit reads 0 is discarded, with no write and no echo.
- R8: The idle timer starts only after the sync character and restarts on every completed character. When `timeoutTicks` clock cycles pass without a new completed character, `done` goes high for exactly one cycle.
- R9: After `done`, further RX traffic causes no write and no echo until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| rxLine | input | 1 | Serial receive line, idle high |
| timeoutTicks | input | TMO_W | Idle gap, in clocks, that ends the download |
| txDriveLow | output | 1 | 1 = pull transmit line low, 0 = release |
| wrEn | output | 1 | Write strobe, one cycle per byte |
| wrAddr | output | ADDR_W | Write address |
| wrData | output | 8 | Write data |
| slowRate | output | 1 | 1 = slow rate selected |
| syncErr | output | 1 | First character was not a recognised sync value |
| done | output | 1 | One-cycle pulse when the download ends |

## Verification
A wrong rate decision shows up at once on `slowRate` and `syncErr`. It shows up again one character later, as garbled write data and garbled echo bytes. A broken address counter or write gating shows up on the first or second `wrEn` of a download. A timer that fails to restart or to stop shows up as a `done` pulse that is missing, comes too early, or is followed by writes. Each of these appears within one character time or one timeout interval of the stimulus that causes it.

// File: rtl/loader_pkg.sv
package loader_pkg;
  localparam int TICKS_PER_BIT = 16;
  localparam int BYTE_BITS = 8;

  typedef struct packed {
    logic rateSlow;   // selects slow tick divider
    logic storeByte;  // write and echo the byte just received
    logic tmoClear;   // restart the idle timer
    logic tmoRun;     // idle timer may count
  } ctlStrobes_t;

  typedef enum logic [1:0] {CTL_SYNC, CTL_LOAD, CTL_FIN} ctlState_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;
  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} txState_t;
endpackage

// File: rtl/loader_dp.sv
module loader_dp
  import loader_pkg::*;
#(
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 104,
  parameter int ADDR_W = 16,
  parameter int TMO_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic [TMO_W-1:0]  timeoutTicks,
  input  ctlStrobes_t       ctl,
  output logic              rxDone,
  output logic [7:0]        rxByte,
  output logic              tmoExpired,
  output logic              txDriveLow,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData
);
  localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int DIV_W = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam int TC_W = $clog2(TICKS_PER_BIT);
  localparam int BI_W = $clog2(BYTE_BITS);
  localparam logic [TC_W-1:0] MID_TICK = TC_W'(TICKS_PER_BIT / 2 - 1);
  localparam logic [TC_W-1:0] END_TICK = TC_W'(TICKS_PER_BIT - 1);
  localparam logic [BI_W-1:0] LAST_BIT = BI_W'(BYTE_BITS - 1);

  // ---------------- oversample tick ----------------
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic tick;

  assign divLimit = ctl.rateSlow ? DIV_W'(SLOW_DIV - 1) : DIV_W'(FAST_DIV - 1);
  assign tick = (divCnt >= divLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  // ---------------- input synchroniser ----------------
  logic [SYNC_STAGES-1:0] syncChain;
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 1'b1;
        else syncChain[g] <= rxLine;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 1'b1;
        else syncChain[g] <= syncChain[g-1];
      end
    end
  end

  logic rxS, rxPrev;
  assign rxS = syncChain[SYNC_STAGES-1];

  // ---------------- receiver ----------------
  rxState_t rxState;
  logic [TC_W-1:0] rxTicks;
  logic [BI_W-1:0] rxBit;
  logic [7:0] rxShift;

  assign rxByte = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxTicks <= '0;
      rxBit   <= '0;
      rxShift <= '0;
      rxPrev  <= 1'b1;
      rxDone  <= 1'b0;
    end else begin
      rxPrev <= rxS;
      rxDone <= 1'b0;
      unique case (rxState)
        RX_IDLE: begin
          if (rxPrev && !rxS) begin
            rxState <= RX_START;
            rxTicks <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (rxTicks == MID_TICK) begin
              rxTicks <= '0;
              rxBit   <= '0;
              rxState <= rxS ? RX_IDLE : RX_DATA;
            end else begin
              rxTicks <= rxTicks + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            rxTicks <= rxTicks + 1'b1;
            if (rxTicks == END_TICK) begin
              rxShift <= {rxS, rxShift[7:1]};
              if (rxBit == LAST_BIT) rxState <= RX_STOP;
              else rxBit <= rxBit + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            rxTicks <= rxTicks + 1'b1;
            if (rxTicks == END_TICK) begin
              rxDone  <= rxS;
              rxState <= RX_IDLE;
            end
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // ---------------- echo transmitter with one holding slot ----------------
  txState_t txState;
  logic [TC_W-1:0] txTicks;
  logic [BI_W-1:0] txBit;
  logic [7:0] txShift;
  logic holdValid;
  logic [7:0] holdByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState   <= TX_IDLE;
      txTicks   <= '0;
      txBit     <= '0;
      txShift   <= '0;
      holdValid <= 1'b0;
      holdByte  <= '0;
    end else begin
      unique case (txState)
        TX_IDLE: begin
          if (holdValid) begin
            txShift   <= holdByte;
            txTicks   <= '0;
            holdValid <= 1'b0;
            txState   <= TX_START;
          end
        end
        TX_START: begin
          if (tick) begin
            txTicks <= txTicks + 1'b1;
            if (txTicks == END_TICK) begin
              txBit   <= '0;
              txState <= TX_DATA;
            end
          end
        end
        TX_DATA: begin
          if (tick) begin
            txTicks <= txTicks + 1'b1;
            if (txTicks == END_TICK) begin
              txShift <= {1'b1, txShift[7:1]};
              if (txBit == LAST_BIT) txState <= TX_STOP;
              else txBit <= txBit + 1'b1;
            end
          end
        end
        TX_STOP: begin
          if (tick) begin
            txTicks <= txTicks + 1'b1;
            if (txTicks == END_TICK) txState <= TX_IDLE;
          end
        end
        default: txState <= TX_IDLE;
      endcase
      if (ctl.storeByte) begin
        holdValid <= 1'b1;
        holdByte  <= rxShift;
      end
    end
  end

  always_comb begin
    unique case (txState)
      TX_START: txDriveLow = 1'b1;
      TX_DATA:  txDriveLow = ~txShift[0];
      default:  txDriveLow = 1'b0;
    endcase
  end

  // ---------------- write port ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrData <= '0;
      wrAddr <= '0;
    end else begin
      wrEn <= ctl.storeByte;
      if (ctl.storeByte) wrData <= rxShift;
      if (wrEn) wrAddr <= wrAddr + 1'b1;
    end
  end

  // ---------------- idle-gap timer ----------------
  logic [TMO_W-1:0] tmoCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmoCnt <= '0;
    else if (ctl.tmoClear) tmoCnt <= '0;
    else if (ctl.tmoRun && (tmoCnt != {TMO_W{1'b1}})) tmoCnt <= tmoCnt + 1'b1;
  end

  assign tmoExpired = ctl.tmoRun && (tmoCnt >= timeoutTicks);
endmodule

// File: rtl/loader_ctrl.sv
module loader_ctrl
  import loader_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxDone,
  input  logic [7:0]  rxByte,
  input  logic        tmoExpired,
  output ctlStrobes_t ctl,
  output logic        slowRate,
  output logic        syncErr,
  output logic        done
);
  localparam logic [7:0] SYNC_FAST = 8'hFF;
  localparam logic [7:0] SYNC_SLOW_A = 8'hC0;
  localparam logic [7:0] SYNC_SLOW_B = 8'hE0;

  ctlState_t state;
  logic slowReg;
  logic errReg;
  logic doneReg;

  always_comb begin
    ctl.rateSlow  = slowReg;
    ctl.storeByte = (state == CTL_LOAD) && rxDone;
    ctl.tmoRun    = (state == CTL_LOAD);
    ctl.tmoClear  = rxDone || (state != CTL_LOAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= CTL_SYNC;
      slowReg <= 1'b0;
      errReg  <= 1'b0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        CTL_SYNC: begin
          if (rxDone) begin
            state <= CTL_LOAD;
            if ((rxByte == SYNC_SLOW_A) || (rxByte == SYNC_SLOW_B)) slowReg <= 1'b1;
            else if (rxByte != SYNC_FAST) errReg <= 1'b1;
          end
        end
        CTL_LOAD: begin
          if (tmoExpired && !rxDone) begin
            doneReg <= 1'b1;
            state   <= CTL_FIN;
          end
        end
        CTL_FIN: state <= CTL_FIN;
        default: state <= CTL_SYNC;
      endcase
    end
  end

  assign slowRate = slowReg;
  assign syncErr  = errReg;
  assign done     = doneReg;
endmodule

// File: rtl/autobaud_loader.sv
module autobaud_loader
  import loader_pkg::*;
#(
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 104,
  parameter int ADDR_W = 16,
  parameter int TMO_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic [TMO_W-1:0]  timeoutTicks,
  output logic              txDriveLow,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              slowRate,
  output logic              syncErr,
  output logic              done
);
  ctlStrobes_t ctl;
  logic rxDone;
  logic [7:0] rxByte;
  logic tmoExpired;

  loader_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxDone(rxDone), .rxByte(rxByte),
    .tmoExpired(tmoExpired), .ctl(ctl), .slowRate(slowRate),
    .syncErr(syncErr), .done(done)
  );

  loader_dp #(
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .ADDR_W(ADDR_W),
    .TMO_W(TMO_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .timeoutTicks(timeoutTicks),
    .ctl(ctl), .rxDone(rxDone), .rxByte(rxByte), .tmoExpired(tmoExpired),
    .txDriveLow(txDriveLow), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: rtl/autobaud_loader_chk.sv
module autobaud_loader_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              slowRate,
  input logic              syncErr,
  input logic              done
);
  logic doneSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneSeen <= 1'b0;
    else if (done) doneSeen <= 1'b1;
  end

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (wrAddr == $past(wrAddr) + 1'b1));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(wrAddr));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneSeen |-> !wrEn);

  // R3
  rate_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    slowRate |=> slowRate);

  // R4
  err_rate_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(syncErr && slowRate));
endmodule

bind autobaud_loader autobaud_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .slowRate(slowRate), .syncErr(syncErr), .done(done)
);

// File: tb/autobaud_loader_bench.sv
`timescale 1ns/1ps
module autobaud_loader_bench;
  localparam int FAST_DIV = 2;
  localparam int SLOW_DIV = 13;
  localparam int ADDR_W = 16;
  localparam int TMO_W = 16;
  localparam int TMO = 6000;
  localparam int FAST_BIT = 16 * FAST_DIV;
  localparam int SLOW_BIT = 16 * SLOW_DIV;
  localparam int NVEC = 5;

  // {syncByte[26:19], syncSentSlow[18], expSlow[17], expErr[16], d0[15:8], d1[7:0]}
  localparam logic [26:0] VEC [NVEC] = '{
    {8'hFF, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
    {8'hFF, 1'b1, 1'b1, 1'b0, 8'h5A, 8'h81},
    {8'h12, 1'b0, 1'b0, 1'b1, 8'h0F, 8'hF0},
    {8'hC0, 1'b0, 1'b1, 1'b0, 8'h00, 8'hFF},
    {8'hE0, 1'b0, 1'b1, 1'b0, 8'h7E, 8'h01}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1;
  logic [TMO_W-1:0] timeoutTicks = TMO_W'(TMO);
  logic txDriveLow, wrEn, slowRate, syncErr, done;
  logic [ADDR_W-1:0] wrAddr;
  logic [7:0] wrData;

  always #2 clk = ~clk;

  autobaud_loader #(
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .ADDR_W(ADDR_W), .TMO_W(TMO_W)
  ) u_autobaud_loader (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .timeoutTicks(timeoutTicks),
    .txDriveLow(txDriveLow), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .slowRate(slowRate), .syncErr(syncErr), .done(done)
  );

  int checks = 0;
  int fails = 0;
  logic expSlow = 1'b0;

  int wrCnt = 0;
  int doneCnt = 0;
  logic [ADDR_W-1:0] wrA [8];
  logic [7:0] wrD [8];
  always @(negedge clk) begin
    if (!rstN) begin
      wrCnt = 0;
      doneCnt = 0;
    end else begin
      if (wrEn && wrCnt < 8) begin
        wrA[wrCnt] = wrAddr;
        wrD[wrCnt] = wrData;
        wrCnt++;
      end
      if (done) doneCnt++;
    end
  end

  int echoCnt = 0;
  logic [7:0] echoD [8];
  initial begin
    forever begin
      @(negedge clk);
      if (!rstN) echoCnt = 0;
      else if (txDriveLow) begin
        automatic int bc = expSlow ? SLOW_BIT : FAST_BIT;
        automatic logic [7:0] b = '0;
        repeat (bc / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (bc) @(negedge clk);
          b[i] = ~txDriveLow;
        end
        repeat (bc) @(negedge clk);
        if (echoCnt < 8) echoD[echoCnt] = b;
        echoCnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    rxLine = 1'b1;
    expSlow = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit slow, input bit stopBit);
    automatic int bc = slow ? SLOW_BIT : FAST_BIT;
    rxLine = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (bc) @(negedge clk);
    end
    rxLine = stopBit;
    repeat (bc) @(negedge clk);
    rxLine = 1'b1;
    repeat (bc) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(txDriveLow == 1'b0, "R1 txDriveLow", txDriveLow, 0);
    check(wrEn == 1'b0, "R1 wrEn", wrEn, 0);
    check(wrAddr == '0, "R1 wrAddr", int'(wrAddr), 0);
    check(slowRate == 1'b0 && syncErr == 1'b0, "R1 rate/err", {slowRate, syncErr}, 0);
    check(done == 1'b0, "R1 done", done, 0);

    // R8: timer does not run before the sync character
    applyReset();
    repeat (TMO + 500) @(negedge clk);
    check(doneCnt == 0, "R8 no done before sync", doneCnt, 0);

    for (int v = 0; v < NVEC; v++) begin
      automatic logic [7:0] sb = VEC[v][26:19];
      automatic bit sSlow = VEC[v][18];
      automatic bit eSlow = VEC[v][17];
      automatic bit eErr = VEC[v][16];
      automatic logic [7:0] d0 = VEC[v][15:8];
      automatic logic [7:0] d1 = VEC[v][7:0];
      automatic int bc;
      applyReset();
      sendByte(sb, sSlow, 1'b1);
      // R2 R3 R4: rate decision from the first character
      check(slowRate == eSlow, "R2/R3 slowRate", slowRate, eSlow);
      check(syncErr == eErr, "R4 syncErr", syncErr, eErr);
      expSlow = eSlow;
      bc = eSlow ? SLOW_BIT : FAST_BIT;
      sendByte(d0, eSlow, 1'b1);
      sendByte(d1, eSlow, 1'b1);
      repeat (12 * bc) @(negedge clk);
      // R5: writes, sync not written
      check(wrCnt == 2, "R5 write count", wrCnt, 2);
      check(wrA[0] == 0 && wrD[0] == d0, "R5 first write", {wrA[0], wrD[0]}, {16'd0, d0});
      check(wrA[1] == 1 && wrD[1] == d1, "R5 second write", {wrA[1], wrD[1]}, {16'd1, d1});
      // R6: echo
      check(echoCnt == 2, "R6 echo count", echoCnt, 2);
      check(echoD[0] == d0, "R6 echo byte 0", echoD[0], d0);
      check(echoD[1] == d1, "R6 echo byte 1", echoD[1], d1);
      // R8: timer restarted by each character
      check(doneCnt == 0, "R8 no early done", doneCnt, 0);
      repeat (TMO + 200) @(negedge clk);
      check(doneCnt == 1, "R8 done pulse", doneCnt, 1);
      // R9: ignored after done
      sendByte(d0, eSlow, 1'b1);
      repeat (12 * bc) @(negedge clk);
      check(wrCnt == 2, "R9 no write after done", wrCnt, 2);
      check(echoCnt == 2, "R9 no echo after done", echoCnt, 2);
      check(doneCnt == 1, "R9 single done", doneCnt, 1);
    end

    // R7: frame with bad stop bit is discarded
    applyReset();
    sendByte(8'hFF, 1'b0, 1'b1);
    sendByte(8'h77, 1'b0, 1'b0);
    sendByte(8'h99, 1'b0, 1'b1);
    repeat (12 * FAST_BIT) @(negedge clk);
    check(wrCnt == 1, "R7 bad frame dropped", wrCnt, 1);
    check(wrA[0] == 0 && wrD[0] == 8'h99, "R7 next byte at addr 0", {wrA[0], wrD[0]}, {16'd0, 8'h99});
    check(echoCnt == 1 && echoD[0] == 8'h99, "R7 echo only good byte", echoD[0], 8'h99);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule